// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two N-bit two's-complement numbers over several clock cycles. It handles one multiplier bit per cycle. A start pulse loads the operands. Each later cycle looks at the lowest multiplier bit together with the bit that was shifted out just before it. From that pair it adds the multiplicand to the running upper half, subtracts it, or leaves the upper half alone. It then shifts the whole working register right by one place and copies the sign bit into the top.

After N such steps the block raises a one-cycle completion flag. The 2N-bit signed product stays on the output until the next accepted start. While a run is in progress, the block ignores further start pulses. The running upper half is kept one bit wider than the operands, so the most negative operand value is multiplied correctly.

Top module: `booth_seq_mult`

## Requirements
- R1: During reset and after it is released, busy_o and done_o are 0 and product_o is all zeros.
- R2: A start_i sampled high while the block is idle loads both operands. busy_o is 1 from the next cycle on, for exactly N cycles.
- R3: busy_o falls on the clock edge of the N-th step. On that same edge done_o rises for exactly one cycle, and done_o is never 1 while busy_o is 1.
- R4: When done_o is 1, product_o equals the signed product of mcand_i and mplr_i as loaded at start, as a 2N-bit two's-complement value, for every pair of operands.
- R5: A bit pair (current, previous) of 10 subtracts the multiplicand, 01 adds it, and 00 or 11 leaves the upper half unchanged. For example, 2 × (−3) gives 8'hFA.
- R6: The most negative operand −2^(N−1) is handled without overflow: −8 × −8 gives 8'h40 and −8 × 7 gives 8'hC8.
- R7: Once a run is complete, product_o holds its value until the next accepted start.
- R8: A start_i that arrives while busy_o is 1 is ignored. It does not change the result, the operands in use, or the timing of done_o.
- R9: Products at the extremes come out right: +7 × +7 gives 8'h31 and −7 × +7 gives 8'hCF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request; accepted only when idle |
| mcand_i | input | N | Signed multiplicand |
| mplr_i | input | N | Signed multiplier |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2N | Signed product, held until the next start |

## Verification
The bench runs every operand pair for N = 4 and compares each product with an arithmetic product computed in the bench. It therefore catches a design that shifts logically instead of arithmetically, since that would give wrong values for negative partial results. It also catches a design that swaps the add and subtract cases, because the product sign would then be flipped.

The −8 operand cases expose an upper half that is only N bits wide, because the sum then wraps and gives the wrong result. Separate runs inject a start pulse in the middle of a run with different operands and then watch the output after completion. These runs expose a design that reloads operands while busy, or that lets the product drift after done.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_i,
  input  logic      prev_i,
  output booth_op_e op_o
);
  always_comb begin
    unique case ({cur_i, prev_i})
      2'b10:   op_o = OP_SUB;   // run of ones begins
      2'b01:   op_o = OP_ADD;   // run of ones ends
      default: op_o = OP_SKIP;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int unsigned N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [CW-1:0] cnt_q;
  logic          last;

  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign last   = busy_o && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= last;
      if (load_o) begin
        cnt_q  <= CW'(N);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        cnt_q <= cnt_q - CW'(1);
        if (last) busy_o <= 1'b0;
      end
    end
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_FALL_GIVES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R3
  AST_START_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !last) |=> busy_o && !done_o); // R8
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplr_i,
  output logic [2*N-1:0] product_o
);
  localparam int unsigned AW = N + 1;  // guard bit for -2^(N-1)

  logic [N-1:0]  mcand_q;
  logic [AW-1:0] acc_q;
  logic [N-1:0]  low_q;
  logic          ext_q;
  logic [AW-1:0] mc_ext;
  logic [AW-1:0] sum;
  booth_op_e     op;

  booth_recode u_recode (
    .cur_i  (low_q[0]),
    .prev_i (ext_q),
    .op_o   (op)
  );

  assign mc_ext = {mcand_q[N-1], mcand_q};

  always_comb begin
    unique case (op)
      OP_ADD:  sum = acc_q + mc_ext;
      OP_SUB:  sum = acc_q - mc_ext;
      default: sum = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      acc_q   <= '0;
      low_q   <= '0;
      ext_q   <= 1'b0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      acc_q   <= '0;
      low_q   <= mplr_i;
      ext_q   <= 1'b0;
    end else if (step_i) begin
      acc_q <= {sum[AW-1], sum[AW-1:1]};  // arithmetic shift
      low_q <= {sum[0], low_q[N-1:1]};
      ext_q <= low_q[0];
    end
  end

  assign product_o = {acc_q[N-1:0], low_q};

  AST_LOAD_STEP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i)); // R8
  AST_MCAND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mcand_q)); // R8
  AST_PRODUCT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(product_o)); // R7
  AST_SIGN_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (acc_q[AW-1] == acc_q[AW-2]) || !$past(step_i)); // R6
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
  parameter int unsigned N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplr_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*N-1:0] product_o
);
  logic load, step;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  booth_datapath #(.N(N)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .mcand_i   (mcand_i),
    .mplr_i    (mplr_i),
    .product_o (product_o)
  );
endmodule

// File: tb/booth_seq_mult_tb_top.sv
module booth_seq_mult_tb_top;
  localparam int N = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [N-1:0]   mcand_i = '0;
  logic [N-1:0]   mplr_i = '0;
  logic           busy_o, done_o;
  logic [2*N-1:0] product_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  booth_seq_mult #(.N(N)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return p[2*N-1:0];
  endfunction

  // mid: inject a start with other operands during the run (R8)
  task automatic run(logic [N-1:0] a, logic [N-1:0] b, bit mid, bit full);
    logic [2*N-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk_i);
    start_i = 1'b1; mcand_i = a; mplr_i = b;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    if (full) chk("R2 busy after start", 32'(busy_o), 32'd1);
    for (int i = 1; i < N; i++) begin
      if (mid && i == 1) begin
        start_i = 1'b1; mcand_i = ~a; mplr_i = b + 4'd1;
      end
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      if (full) begin
        chk("R2 busy held", 32'(busy_o), 32'd1);
        chk("R3 no early done", 32'(done_o), 32'd0);
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R3 done pulse", 32'(done_o), 32'd1);
    chk("R3 busy fell", 32'(busy_o), 32'd0);
    chk(mid ? "R8 product after ignored start" : "R4 product", 32'(product_o), 32'(exp));
    if (full) begin
      repeat (3) @(negedge clk_i);
      chk("R3 done single", 32'(done_o), 32'd0);
      chk("R7 product held", 32'(product_o), 32'(exp));
    end
  endtask

  initial begin
    #3;
    chk("R1 busy in reset", 32'(busy_o), 32'd0);
    chk("R1 product in reset", 32'(product_o), 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 product", 32'(product_o), 32'd0);

    run(4'd2, 4'hD, 1'b0, 1'b1);   // R5 2*-3
    chk("R5 2x-3", 32'(product_o), 32'hFA);
    run(4'd7, 4'd7, 1'b0, 1'b1);   // R9
    chk("R9 7x7", 32'(product_o), 32'h31);
    run(4'h9, 4'd7, 1'b0, 1'b1);   // R9
    chk("R9 -7x7", 32'(product_o), 32'hCF);
    run(4'h8, 4'h8, 1'b0, 1'b1);   // R6
    chk("R6 -8x-8", 32'(product_o), 32'h40);
    run(4'h8, 4'd7, 1'b0, 1'b1);   // R6
    chk("R6 -8x7", 32'(product_o), 32'hC8);
    run(4'h3, 4'hA, 1'b1, 1'b1);   // R8
    run(4'h8, 4'h5, 1'b1, 1'b1);   // R8

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run(4'(a), 4'(b), 1'b0, 1'b0);  // R4 exhaustive

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule